// File: doc/BRIEF.md
# GPIO Interrupt Channel Multiplexer

This block takes a wide bank of GPIO pad interrupt lines and funnels a chosen few onto eight interrupt channels for a downstream interrupt controller. The downstream controller only understands active-high levels and rising edges. Each channel therefore picks one pad and can invert it. It can also debounce it and turn it into a level or a single-cycle pulse. An active-low level or a falling edge on a pad then arrives downstream in one of the two forms the controller accepts.

Software programs the block through a small word-addressed register port. One register holds the per-channel mode and inversion bits. Two registers hold the per-channel pad indices. One register holds the per-channel debounce settings. Reads are combinational. A write takes effect at the clock edge on which `regWe` is sampled high. The selected pad is synchronized through two flops. It is then corrected for polarity and passed through an optional stability filter. After that it is either forwarded as a level or edge-detected.

Top module: `gpio_irq_chan_mux`

## Requirements
- R1: After reset every register reads 0x00000000 and `irqOut` is all zero (level mode, no inversion, pad 0, no filtering).
- R2: The register at byte offset 0x0 holds channel n's edge-mode flag in bit n and its inversion flag in bit 16+n; bits 8..15 and 24..31 read as zero.
- R3: Offset 0x4 holds the 8-bit pad index of channels 0..3 and offset 0x8 that of channels 4..7, channel n at bit (n mod 4)*8; both read back exactly what was written.
- R4: Offset 0xC holds a 4-bit filter value per channel at bit n*4 and reads back exactly what was written.
- R5: An access whose address bits 1..0 are not zero is ignored: a write changes no register and a read returns zero.
- R6: In level mode without inversion and with filter 0, channel n's output equals the selected pad, changing on the third clock edge after the pad changes.
- R7: In level mode with inversion the output is high while the pad is low; a configuration write changes the output on the edge after the write edge.
- R8: In edge mode without inversion a rising pad produces a one-cycle output pulse on the third edge, and a falling pad produces none.
- R9: In edge mode with inversion a falling pad produces a one-cycle pulse and a rising pad produces none.
- R10: With filter value k>0 the filtered level follows the corrected input only after it has differed for 8*k consecutive cycles, so the output moves 2+8k edges after a lasting pad change; a shorter excursion leaves the output unchanged.
- R11: A pad that no channel selects has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Byte address of the register access |
| regWe | input | 1 | Write enable, sampled at the rising clock edge |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| padIn | input | NUM_PADS | Asynchronous pad interrupt lines |
| irqOut | output | NUM_CH | Active-high channel interrupts |

## Verification
Reads are due in the same cycle the address is applied. A configuration change is due one edge after the write edge. A pad change reaches the output three edges later with no filter, or 2+8k edges later with filter k. An edge pulse lasts exactly one cycle. The driver stamps every expected item with the cycle number of its due edge and pushes it onto the scoreboard. The monitor samples at the falling edge and compares only the items stamped for the current cycle. Checks one cycle before a due edge and one cycle after a pulse pin the latency and the pulse width exactly.

// File: rtl/gim_pkg.sv
package gim_pkg;
  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 4;
  localparam int SEL_SLOT    = 8;   // bits reserved per pad index field
  localparam int INV_BASE    = 16;  // first inversion bit in the mode register
  localparam int CH_PER_WORD = DATA_W / SEL_SLOT;

  typedef enum logic [2:0] {
    RD_MODE,
    RD_SEL_LO,
    RD_SEL_HI,
    RD_FILT,
    RD_NONE
  } rdSel_e;

  typedef struct packed {
    logic wrMode;
    logic wrSelLo;
    logic wrSelHi;
    logic wrFilt;
  } cfgStrobe_t;
endpackage

// File: rtl/gim_ctrl.sv
module gim_ctrl
  import gim_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  output cfgStrobe_t        strobe,
  output rdSel_e            rdSel
);
  logic aligned;
  logic [1:0] wordIdx;

  assign aligned = (regAddr[1:0] == 2'b00);
  assign wordIdx = regAddr[3:2];

  always_comb begin
    strobe = '0;
    if (regWe && aligned) begin
      strobe.wrMode  = (wordIdx == 2'd0);
      strobe.wrSelLo = (wordIdx == 2'd1);
      strobe.wrSelHi = (wordIdx == 2'd2);
      strobe.wrFilt  = (wordIdx == 2'd3);
    end
  end

  always_comb begin
    if (!aligned) begin
      rdSel = RD_NONE;
    end else begin
      unique case (wordIdx)
        2'd0:    rdSel = RD_MODE;
        2'd1:    rdSel = RD_SEL_LO;
        2'd2:    rdSel = RD_SEL_HI;
        default: rdSel = RD_FILT;
      endcase
    end
  end
endmodule

// File: rtl/gim_channel.sv
module gim_channel #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_W      = 4,
  parameter int FILT_UNIT   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rawIn,
  input  logic              invert,
  input  logic              edgeMode,
  input  logic [FILT_W-1:0] filtSel,
  output logic              irq
);
  localparam int CNT_MAX = ((1 << FILT_W) - 1) * FILT_UNIT;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   corrected;
  logic                   filtLvl;
  logic                   prevLvl;
  logic [CNT_W-1:0]       holdCnt;
  logic [CNT_W-1:0]       holdLimit;
  logic                   holdDone;

  always_ff @(posedge clk) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], rawIn};
  end

  assign corrected = syncChain[SYNC_STAGES-1] ^ invert;
  assign holdLimit = CNT_W'(int'(filtSel) * FILT_UNIT);
  assign holdDone  = (filtSel == '0) || (holdCnt == holdLimit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      filtLvl <= 1'b0;
      prevLvl <= 1'b0;
      holdCnt <= '0;
    end else begin
      prevLvl <= filtLvl;
      if (corrected == filtLvl) begin
        holdCnt <= '0;
      end else if (holdDone) begin
        filtLvl <= corrected;
        holdCnt <= '0;
      end else begin
        holdCnt <= holdCnt + CNT_W'(1);
      end
    end
  end

  assign irq = edgeMode ? (filtLvl & ~prevLvl) : filtLvl;
endmodule

// File: rtl/gim_datapath.sv
module gim_datapath
  import gim_pkg::*;
#(
  parameter int NUM_PADS    = 256,
  parameter int NUM_CH      = 8,
  parameter int FILT_W      = 4,
  parameter int FILT_UNIT   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  cfgStrobe_t               strobe,
  input  rdSel_e                   rdSel,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  input  logic [NUM_PADS-1:0]      padIn,
  output logic [NUM_CH-1:0]        irqOut,
  output logic [NUM_CH-1:0]        cfgEdge,
  output logic [NUM_CH*FILT_W-1:0] cfgFilt
);
  localparam int SEL_W = $clog2(NUM_PADS);

  logic [NUM_CH-1:0] edgeMode;
  logic [NUM_CH-1:0] invMask;
  logic [SEL_W-1:0]  padSel  [NUM_CH];
  logic [FILT_W-1:0] filtSel [NUM_CH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgeMode <= '0;
      invMask  <= '0;
      for (int n = 0; n < NUM_CH; n++) begin
        padSel[n]  <= '0;
        filtSel[n] <= '0;
      end
    end else begin
      if (strobe.wrMode) begin
        edgeMode <= wdata[NUM_CH-1:0];
        invMask  <= wdata[INV_BASE +: NUM_CH];
      end
      for (int n = 0; n < NUM_CH; n++) begin
        if ((n <  CH_PER_WORD && strobe.wrSelLo) ||
            (n >= CH_PER_WORD && strobe.wrSelHi))
          padSel[n] <= wdata[(n % CH_PER_WORD)*SEL_SLOT +: SEL_W];
        if (strobe.wrFilt)
          filtSel[n] <= wdata[n*FILT_W +: FILT_W];
      end
    end
  end

  always_comb begin
    rdata = '0;
    unique case (rdSel)
      RD_MODE: begin
        rdata[NUM_CH-1:0]          = edgeMode;
        rdata[INV_BASE +: NUM_CH]  = invMask;
      end
      RD_SEL_LO:
        for (int n = 0; n < CH_PER_WORD; n++)
          rdata[n*SEL_SLOT +: SEL_W] = padSel[n];
      RD_SEL_HI:
        for (int n = 0; n < CH_PER_WORD; n++)
          rdata[n*SEL_SLOT +: SEL_W] = padSel[n + CH_PER_WORD];
      RD_FILT:
        for (int n = 0; n < NUM_CH; n++)
          rdata[n*FILT_W +: FILT_W] = filtSel[n];
      default: rdata = '0;
    endcase
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
    logic picked;
    assign picked = padIn[padSel[n]];
    assign cfgFilt[n*FILT_W +: FILT_W] = filtSel[n];

    gim_channel #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_W     (FILT_W),
      .FILT_UNIT  (FILT_UNIT)
    ) u_chan (
      .clk     (clk),
      .rstN    (rstN),
      .rawIn   (picked),
      .invert  (invMask[n]),
      .edgeMode(edgeMode[n]),
      .filtSel (filtSel[n]),
      .irq     (irqOut[n])
    );
  end

  assign cfgEdge = edgeMode;
endmodule

// File: rtl/gpio_irq_chan_mux.sv
module gpio_irq_chan_mux
  import gim_pkg::*;
#(
  parameter int NUM_PADS    = 256,
  parameter int NUM_CH      = 8,
  parameter int FILT_W      = 4,
  parameter int FILT_UNIT   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [3:0]          regAddr,
  input  logic                regWe,
  input  logic [31:0]         regWdata,
  output logic [31:0]         regRdata,
  input  logic [NUM_PADS-1:0] padIn,
  output logic [NUM_CH-1:0]   irqOut
);
  cfgStrobe_t                strobe;
  rdSel_e                    rdSel;
  logic [NUM_CH-1:0]         cfgEdge;
  logic [NUM_CH*FILT_W-1:0]  cfgFilt;

  gim_ctrl u_ctrl (
    .regAddr(regAddr),
    .regWe  (regWe),
    .strobe (strobe),
    .rdSel  (rdSel)
  );

  gim_datapath #(
    .NUM_PADS   (NUM_PADS),
    .NUM_CH     (NUM_CH),
    .FILT_W     (FILT_W),
    .FILT_UNIT  (FILT_UNIT),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .rdSel  (rdSel),
    .wdata  (regWdata),
    .rdata  (regRdata),
    .padIn  (padIn),
    .irqOut (irqOut),
    .cfgEdge(cfgEdge),
    .cfgFilt(cfgFilt)
  );
endmodule

// File: rtl/gim_checker.sv
module gim_checker #(
  parameter int NUM_CH = 8,
  parameter int FILT_W = 4
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [3:0]               regAddr,
  input logic                     regWe,
  input logic [31:0]              regWdata,
  input logic [31:0]              regRdata,
  input logic [NUM_CH-1:0]        irqOut,
  input logic [NUM_CH-1:0]        cfgEdge,
  input logic [NUM_CH*FILT_W-1:0] cfgFilt
);
  AST_OUTPUTS_LOW_AFTER_RESET: assert property (@(posedge clk)
    $rose(rstN) |-> (irqOut == '0)); // R1

  AST_MODE_GAPS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 4'h0) |-> (regRdata[31:24] == 8'h0 && regRdata[15:8] == 8'h0)); // R2

  AST_SEL_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 4'h4) |=> (regAddr != 4'h4) || (regRdata == $past(regWdata))); // R3

  AST_MISALIGNED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr[1:0] != 2'b00) |-> (regRdata == 32'h0)); // R5

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    AST_EDGE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
      (irqOut[n] && cfgEdge[n] && !regWe) |=> !irqOut[n]); // R8

    AST_FILTER_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (!cfgEdge[n] && cfgFilt[n*FILT_W +: FILT_W] != '0 && !regWe && $past(!regWe)
       && irqOut[n] != $past(irqOut[n])) |=> $stable(irqOut[n])); // R10
  end
endmodule

bind gpio_irq_chan_mux gim_checker #(.NUM_CH(NUM_CH), .FILT_W(FILT_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .regAddr (regAddr),
  .regWe   (regWe),
  .regWdata(regWdata),
  .regRdata(regRdata),
  .irqOut  (irqOut),
  .cfgEdge (cfgEdge),
  .cfgFilt (cfgFilt)
);

// File: tb/tb_gpio_irq_chan_mux.sv
module tb_gpio_irq_chan_mux;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_PADS   = 256;
  localparam int NUM_CH     = 8;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [3:0]          regAddr = '0;
  logic                regWe = 1'b0;
  logic [31:0]         regWdata = '0;
  logic [31:0]         regRdata;
  logic [NUM_PADS-1:0] padIn = '0;
  logic [NUM_CH-1:0]   irqOut;

  gpio_irq_chan_mux dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .padIn(padIn), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          due;
    bit          isRead;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t queueExp[$];
  int    cycleCnt = 0;
  int    nChecked = 0;
  int    nFailed  = 0;
  bit    done     = 0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  // monitor: compare every item due in this cycle
  always @(negedge clk) begin
    if (rstN) begin
      for (int i = queueExp.size() - 1; i >= 0; i--) begin
        if (queueExp[i].due == cycleCnt) begin
          logic [31:0] got;
          got = queueExp[i].isRead ? regRdata : {24'h0, irqOut};
          nChecked++;
          if (got !== queueExp[i].exp) begin
            nFailed++;
            $display("FAIL %s: got %h expected %h (cycle %0d)",
                     queueExp[i].tag, got, queueExp[i].exp, cycleCnt);
          end
          queueExp.delete(i);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    cyc(1);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    item_t it;
    regAddr = a;
    it.due = cycleCnt; it.isRead = 1; it.exp = e; it.tag = t;
    queueExp.push_back(it);
    cyc(1);
  endtask

  task automatic expIrq(input int dly, input logic [7:0] e, input string t);
    item_t it;
    it.due = cycleCnt + dly; it.isRead = 0; it.exp = {24'h0, e}; it.tag = t;
    queueExp.push_back(it);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecked, nFailed);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    // R1 reset state
    expIrq(0, 8'h00, "R1 irq");
    rd(4'h0, 32'h0, "R1 mode");
    rd(4'h4, 32'h0, "R1 sel lo");
    rd(4'h8, 32'h0, "R1 sel hi");
    rd(4'hC, 32'h0, "R1 filt");

    // R2 mode register layout
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, 32'h00FF_00FF, "R2 mode gaps");
    wr(4'h0, 32'h0);
    cyc(5);

    // R3 pad select registers: ch0..3 = 5,10,20,40 ; ch4..7 = 48,80,160,200
    wr(4'h4, 32'h2814_0A05);
    wr(4'h8, 32'hC8A0_5030);
    rd(4'h4, 32'h2814_0A05, "R3 sel lo");
    rd(4'h8, 32'hC8A0_5030, "R3 sel hi");

    // R5 misaligned access
    wr(4'h6, 32'hFFFF_FFFF);
    rd(4'h4, 32'h2814_0A05, "R5 misaligned write ignored");
    rd(4'h1, 32'h0, "R5 misaligned read zero");

    // R4 filter register
    wr(4'hC, 32'h8765_4321);
    rd(4'hC, 32'h8765_4321, "R4 filt");
    wr(4'hC, 32'h0);
    cyc(3);

    // R6 level mode, pad 5 on ch0
    padIn[5] = 1'b1;
    expIrq(2, 8'h00, "R6 not yet");
    expIrq(3, 8'h01, "R6 level high");
    cyc(4);
    padIn[5] = 1'b0;
    expIrq(3, 8'h00, "R6 level low");
    cyc(4);

    // R11 unselected pads
    padIn[0] = 1'b1; padIn[6] = 1'b1; padIn[255] = 1'b1;
    expIrq(3, 8'h00, "R11 isolation");
    expIrq(5, 8'h00, "R11 isolation late");
    cyc(6);
    padIn[0] = 1'b0; padIn[6] = 1'b0; padIn[255] = 1'b0;
    cyc(3);

    // R7 level inverted on ch1 (pad 10)
    wr(4'h0, 32'h0002_0000);
    expIrq(0, 8'h00, "R7 write edge");
    expIrq(1, 8'h02, "R7 inverted idle high");
    cyc(2);
    padIn[10] = 1'b1;
    expIrq(3, 8'h00, "R7 pad high gives low");
    cyc(4);
    padIn[10] = 1'b0;
    expIrq(3, 8'h02, "R7 pad low gives high");
    cyc(4);
    wr(4'h0, 32'h0);
    cyc(3);

    // R8 edge mode on ch2 (pad 20)
    wr(4'h0, 32'h0000_0004);
    cyc(1);
    padIn[20] = 1'b1;
    expIrq(2, 8'h00, "R8 not yet");
    expIrq(3, 8'h04, "R8 pulse");
    expIrq(4, 8'h00, "R8 pulse one cycle");
    expIrq(6, 8'h00, "R8 held high no repeat");
    cyc(7);
    padIn[20] = 1'b0;
    expIrq(3, 8'h00, "R8 fall no pulse");
    expIrq(4, 8'h00, "R8 fall no pulse late");
    cyc(5);

    // R9 edge inverted on ch3 (pad 40); enabling gives one pulse
    wr(4'h0, 32'h0008_0008);
    expIrq(1, 8'h08, "R9 enable pulse");
    expIrq(2, 8'h00, "R9 enable pulse end");
    cyc(4);
    padIn[40] = 1'b1;
    expIrq(3, 8'h00, "R9 rise no pulse");
    expIrq(4, 8'h00, "R9 rise no pulse late");
    cyc(5);
    padIn[40] = 1'b0;
    expIrq(3, 8'h08, "R9 fall pulse");
    expIrq(4, 8'h00, "R9 fall pulse one cycle");
    cyc(5);
    wr(4'h0, 32'h0);
    cyc(3);

    // R10 filter k=2 on ch4 (pad 48)
    wr(4'hC, 32'h0002_0000);
    cyc(1);
    padIn[48] = 1'b1;
    expIrq(17, 8'h00, "R10 not yet");
    expIrq(18, 8'h10, "R10 filtered rise");
    cyc(20);
    padIn[48] = 1'b0;
    expIrq(3, 8'h10, "R10 glitch ignored");
    expIrq(12, 8'h10, "R10 glitch ignored mid");
    cyc(10);
    padIn[48] = 1'b1;
    expIrq(10, 8'h10, "R10 glitch ignored end");
    cyc(12);
    padIn[48] = 1'b0;
    expIrq(17, 8'h10, "R10 not yet fall");
    expIrq(18, 8'h00, "R10 filtered fall");
    cyc(20);
    wr(4'hC, 32'h0);
    cyc(5);

    if (queueExp.size() != 0) begin
      nFailed++;
      $display("FAIL scoreboard: got %0d pending expected 0", queueExp.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecked, nFailed);
    $finish;
  end
endmodule